// File: doc/BRIEF.md
# Iterative Multiply/Divide Engine with HI/LO Result Pair

This block performs 32-bit integer multiplication and division, both signed and unsigned, over a series of cycles. The results go into two result registers that only this block owns, named HI and LO. A multiply puts the 64-bit product across the pair, with the upper word in HI and the lower word in LO. A divide puts the quotient in LO and the remainder in HI. The surrounding pipeline can also load either register directly, and it can read both registers at any time.

An operation is launched with a one-cycle start strobe. The strobe carries a 6-bit function code and two operands. Both kinds of operation use a single 33-bit add/subtract step, which runs once per operand bit on operand magnitudes. A final cycle corrects the signs and commits the result. While the engine works, `busy_o` is high and the old HI/LO values stay visible. A consumer that wants a fresh result stalls on `busy_o`. The block has no decoder and no interlock logic of its own.

Top module: `muldiv_unit`

## Requirements
- R1: While reset is held, `busy_o` is 0 and both `hi_o` and `lo_o` are 0.
- R2: A start pulse launches an operation when the unit is idle and `func_i` is one of 6'b011000 (signed multiply), 6'b011001 (unsigned multiply), 6'b011010 (signed divide) or 6'b011011 (unsigned divide). `busy_o` then goes high in the next cycle. A start with any other code leaves `busy_o` low and HI/LO unchanged.
- R3: Unsigned multiply writes bits 63:32 of the 64-bit product to HI and bits 31:0 to LO.
- R4: Signed multiply treats both operands as two's complement and writes the 64-bit two's-complement product in the same split as R3.
- R5: Unsigned divide writes the quotient to LO and the remainder to HI.
- R6: Signed divide truncates the quotient toward zero, and the remainder takes the sign of the dividend. Dividing 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R7: `busy_o` stays high for exactly WIDTH+1 cycles (33 by default). HI and LO take the new result in the cycle where `busy_o` returns low.
- R8: While `busy_o` is high, `hi_o` and `lo_o` keep the values they had before the operation started.
- R9: A start pulse that arrives while `busy_o` is high is ignored. The running result is not disturbed and no further operation follows.
- R10: When the unit is idle and no operation is being accepted, `mthi_i` loads `mt_data_i` into HI and `mtlo_i` loads it into LO in the next cycle. Both strobes may be asserted together.
- R11: Move-to strobes have no effect while `busy_o` is high. They also have no effect in the cycle an operation is accepted, because the start takes priority.
- R12: A divide by zero does not hang. It completes in the same WIDTH+1 cycles, and the values it leaves in HI and LO are not defined by this specification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request to launch an operation |
| func_i | input | 6 | Function code of the requested operation |
| opa_i | input | 32 | First operand (multiplicand or dividend) |
| opb_i | input | 32 | Second operand (multiplier or divisor) |
| mthi_i | input | 1 | Load `mt_data_i` into HI |
| mtlo_i | input | 1 | Load `mt_data_i` into LO |
| mt_data_i | input | 32 | Data for direct HI/LO loads |
| busy_o | output | 1 | Operation in progress |
| hi_o | output | 32 | Current HI contents |
| lo_o | output | 32 | Current LO contents |

## Verification
Two collisions can fall in the same cycle: a direct HI/LO load with an operation start, and a direct load or a second start with a running operation. The bench provokes the first by raising `mthi_i` in the very cycle it issues a multiply. It provokes the second by strobing a move-to and a new start partway through a busy period. In each case the scoreboard expects only the launched operation's result when `busy_o` falls. Any extra completion, or a HI/LO value that changed while busy, is counted as a failure.

// File: rtl/muldiv_pkg.sv
// Shared definitions for the multiply/divide engine: function codes and
// the sequencing states. Assumes the decoder passes the 6-bit function field.
package muldiv_pkg;
    localparam logic [5:0] FN_MULS = 6'b011000;
    localparam logic [5:0] FN_MULU = 6'b011001;
    localparam logic [5:0] FN_DIVS = 6'b011010;
    localparam logic [5:0] FN_DIVU = 6'b011011;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } md_state_t;
endpackage

// File: rtl/muldiv_ctrl.sv
// Sequencer: after an accepted start it runs ITER iteration cycles and then
// one commit cycle. Assumes accept is only raised while idle.
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int ITER = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic running,
    output logic finish,
    output logic busy
);
    localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;

    md_state_t      state;
    logic [CW-1:0]  cnt;

    // State and iteration counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state <= ST_RUN;
                    cnt   <= '0;
                end
                ST_RUN: begin
                    if (cnt == CW'(ITER - 1)) state <= ST_FIN;
                    else                      cnt   <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decoded status outputs
    always_comb begin
        running = (state == ST_RUN);
        finish  = (state == ST_FIN);
        busy    = (state != ST_IDLE);
    end
endmodule

// File: rtl/muldiv_operand.sv
// Operand conditioning: turns signed operands into magnitudes and reports
// their signs. Assumes two's complement inputs; unsigned ops pass through.
module muldiv_operand #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             is_signed,
    output logic [WIDTH-1:0] a_mag,
    output logic [WIDTH-1:0] b_mag,
    output logic             a_neg,
    output logic             b_neg
);
    // Sign detection and magnitude selection
    always_comb begin
        a_neg = is_signed & a[WIDTH-1];
        b_neg = is_signed & b[WIDTH-1];
        a_mag = a_neg ? -a : a;
        b_mag = b_neg ? -b : b;
    end
endmodule

// File: rtl/muldiv_step.sv
// One radix-2 iteration on the {hi,lo} work pair through a single adder:
// shift-add for multiply, restoring shift-subtract for divide.
// Assumes m holds the multiplicand or divisor magnitude.
module muldiv_step #(
    parameter int WIDTH = 32
) (
    input  logic             is_div,
    input  logic [WIDTH-1:0] hi,
    input  logic [WIDTH-1:0] lo,
    input  logic [WIDTH-1:0] m,
    output logic [WIDTH-1:0] hi_n,
    output logic [WIDTH-1:0] lo_n
);
    logic [WIDTH:0] sh;
    logic [WIDTH:0] base;
    logic [WIDTH:0] addend;
    logic [WIDTH:0] sum;

    // Shared add/subtract and result steering
    always_comb begin
        sh     = {hi, lo[WIDTH-1]};
        base   = is_div ? sh : {1'b0, hi};
        addend = is_div ? ~{1'b0, m} : (lo[0] ? {1'b0, m} : '0);
        sum    = base + addend + {{WIDTH{1'b0}}, is_div};
        if (is_div) begin
            hi_n = sum[WIDTH] ? sh[WIDTH-1:0] : sum[WIDTH-1:0];
            lo_n = {lo[WIDTH-2:0], ~sum[WIDTH]};
        end else begin
            hi_n = sum[WIDTH:1];
            lo_n = {sum[0], lo[WIDTH-1:1]};
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
// Multiply/divide engine with private HI/LO registers. Iterates on operand
// magnitudes in work registers, then fixes signs and commits to HI/LO in one
// final cycle. Assumes consumers stall on busy_o before reading results.
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [5:0]       func_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             mthi_i,
    input  logic             mtlo_i,
    input  logic [WIDTH-1:0] mt_data_i,
    output logic             busy_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    localparam int DW = 2 * WIDTH;

    logic             fn_ok, accept, running, finish, busy;
    logic [WIDTH-1:0] a_mag, b_mag;
    logic             a_neg, b_neg;
    logic [WIDTH-1:0] w_hi, w_lo, mcand, st_hi, st_lo;
    logic             op_div, op_sgn, neg_a, neg_b;
    logic [WIDTH-1:0] hi_q, lo_q, res_hi, res_lo;
    logic [DW-1:0]    prod_raw, prod_fix;

    // Request decode: accept only a known code while idle
    always_comb begin
        fn_ok  = (func_i[5:2] == FN_MULS[5:2]);
        accept = start_i & fn_ok & ~busy;
    end

    muldiv_ctrl #(.ITER(WIDTH)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .running (running),
        .finish  (finish),
        .busy    (busy)
    );

    muldiv_operand #(.WIDTH(WIDTH)) opnd_i (
        .a         (opa_i),
        .b         (opb_i),
        .is_signed (~func_i[0]),
        .a_mag     (a_mag),
        .b_mag     (b_mag),
        .a_neg     (a_neg),
        .b_neg     (b_neg)
    );

    muldiv_step #(.WIDTH(WIDTH)) step_i (
        .is_div (op_div),
        .hi     (w_hi),
        .lo     (w_lo),
        .m      (mcand),
        .hi_n   (st_hi),
        .lo_n   (st_lo)
    );

    // Work registers: load magnitudes on accept, iterate while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_hi   <= '0;
            w_lo   <= '0;
            mcand  <= '0;
            op_div <= 1'b0;
            op_sgn <= 1'b0;
            neg_a  <= 1'b0;
            neg_b  <= 1'b0;
        end else if (accept) begin
            w_hi   <= '0;
            w_lo   <= a_mag;
            mcand  <= b_mag;
            op_div <= func_i[1];
            op_sgn <= ~func_i[0];
            neg_a  <= a_neg;
            neg_b  <= b_neg;
        end else if (running) begin
            w_hi   <= st_hi;
            w_lo   <= st_lo;
        end
    end

    // Sign correction of the finished magnitudes
    always_comb begin
        prod_raw = {w_hi, w_lo};
        prod_fix = (op_sgn & (neg_a ^ neg_b)) ? -prod_raw : prod_raw;
        if (op_div) begin
            res_lo = (op_sgn & (neg_a ^ neg_b)) ? -w_lo : w_lo;
            res_hi = (op_sgn & neg_a) ? -w_hi : w_hi;
        end else begin
            res_hi = prod_fix[DW-1:WIDTH];
            res_lo = prod_fix[WIDTH-1:0];
        end
    end

    // Architectural HI/LO: commit on finish, direct loads only when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (finish) begin
            hi_q <= res_hi;
            lo_q <= res_lo;
        end else if (!busy && !accept) begin
            if (mthi_i) hi_q <= mt_data_i;
            if (mtlo_i) lo_q <= mt_data_i;
        end
    end

    assign busy_o = busy;
    assign hi_o   = hi_q;
    assign lo_o   = lo_q;
endmodule

// File: rtl/muldiv_unit_chk.sv
// Property checker for muldiv_unit, attached through bind. Observes ports
// only; a local counter measures busy periods.
module muldiv_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [5:0]       func_i,
    input logic             mthi_i,
    input logic             mtlo_i,
    input logic [WIDTH-1:0] mt_data_i,
    input logic             busy_o,
    input logic [WIDTH-1:0] hi_o,
    input logic [WIDTH-1:0] lo_o
);
    localparam int LW = $clog2(WIDTH + 2) + 1;

    logic [LW-1:0] run_len;
    logic          known_fn;

    // Busy-period length counter
    always_ff @(posedge clk) begin
        if (!rst_n)      run_len <= '0;
        else if (busy_o) run_len <= run_len + 1'b1;
        else             run_len <= '0;
    end

    assign known_fn = (func_i == 6'b011000) || (func_i == 6'b011001) ||
                      (func_i == 6'b011010) || (func_i == 6'b011011);

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && known_fn && !busy_o) |=> busy_o);

    p_bad_fn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !known_fn && !busy_o && !mthi_i && !mtlo_i)
        |=> (!busy_o && $stable(hi_o) && $stable(lo_o)));

    p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len == LW'(WIDTH + 1)));

    p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(hi_o) && $stable(lo_o)));

    p_mt_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !(start_i && known_fn) && mthi_i)
        |=> (hi_o == $past(mt_data_i)));

    p_mt_load_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !(start_i && known_fn) && mtlo_i)
        |=> (lo_o == $past(mt_data_i)));
endmodule

bind muldiv_unit muldiv_unit_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .func_i    (func_i),
    .mthi_i    (mthi_i),
    .mtlo_i    (mtlo_i),
    .mt_data_i (mt_data_i),
    .busy_o    (busy_o),
    .hi_o      (hi_o),
    .lo_o      (lo_o)
);

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIDTH      = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [5:0]  func_i = '0;
    logic [31:0] opa_i = '0, opb_i = '0, mt_data_i = '0;
    logic        mthi_i = 1'b0, mtlo_i = 1'b0;
    logic        busy_o;
    logic [31:0] hi_o, lo_o;

    typedef struct {
        logic [31:0] hi;
        logic [31:0] lo;
        bit          care;
        string       req;
    } exp_t;

    exp_t sb_q[$];
    int   n_run = 0;
    int   n_fail = 0;
    int   busy_cnt = 0;
    bit   prev_busy = 1'b0;
    bit   done = 1'b0;

    muldiv_unit #(.WIDTH(WIDTH)) dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .func_i (func_i),
        .opa_i (opa_i), .opb_i (opb_i), .mthi_i (mthi_i), .mtlo_i (mtlo_i),
        .mt_data_i (mt_data_i), .busy_o (busy_o), .hi_o (hi_o), .lo_o (lo_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(bit ok, string req, string what,
                         logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model from the requirements
    function automatic exp_t model(logic [5:0] f, logic [31:0] a,
                                   logic [31:0] b, string req);
        exp_t   e;
        longint sa, sb, q, r;
        logic [63:0] p;
        e.req = req;
        e.care = 1'b1;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (f)
            6'b011000: begin p = 64'(sa * sb); e.hi = p[63:32]; e.lo = p[31:0]; end
            6'b011001: begin p = {32'd0, a} * {32'd0, b}; e.hi = p[63:32]; e.lo = p[31:0]; end
            6'b011010: begin
                if (b == 0) begin e.care = 1'b0; e.hi = '0; e.lo = '0; end
                else begin q = sa / sb; r = sa % sb; e.lo = q[31:0]; e.hi = r[31:0]; end
            end
            default: begin
                if (b == 0) begin e.care = 1'b0; e.hi = '0; e.lo = '0; end
                else begin e.lo = a / b; e.hi = a % b; end
            end
        endcase
        return e;
    endfunction

    // Driver: wait for idle, pulse start, push expected result
    task automatic issue(logic [5:0] f, logic [31:0] a, logic [31:0] b, string req);
        while (busy_o) @(negedge clk);
        start_i = 1'b1; func_i = f; opa_i = a; opb_i = b;
        sb_q.push_back(model(f, a, b, req));
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o || sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: measure busy length and compare each completion
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o) busy_cnt++;
            else if (prev_busy) begin
                check(busy_cnt == WIDTH + 1, "R7", "busy length",
                      64'(busy_cnt), 64'(WIDTH + 1));
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected completion", {hi_o, lo_o}, 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (e.care)
                        check({hi_o, lo_o} == {e.hi, e.lo}, e.req, "hi:lo",
                              {hi_o, lo_o}, {e.hi, e.lo});
                    else
                        check(1'b1, e.req, "completion", 64'd0, 64'd0);
                end
                busy_cnt = 0;
            end
            prev_busy = busy_o;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check(busy_o == 1'b0 && hi_o == 0 && lo_o == 0, "R1", "reset state",
              {31'd0, busy_o, hi_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: direct loads while idle, both together
        mthi_i = 1'b1; mtlo_i = 1'b1; mt_data_i = 32'hA5A5_0001;
        @(negedge clk);
        mthi_i = 1'b0; mtlo_i = 1'b0;
        check(hi_o == 32'hA5A5_0001 && lo_o == 32'hA5A5_0001, "R10", "mt both",
              {hi_o, lo_o}, {2{32'hA5A5_0001}});
        mtlo_i = 1'b1; mt_data_i = 32'h0000_1234;
        @(negedge clk);
        mtlo_i = 1'b0;
        check(hi_o == 32'hA5A5_0001 && lo_o == 32'h1234, "R10", "mt lo only",
              {hi_o, lo_o}, {32'hA5A5_0001, 32'h1234});

        // R2: unknown function code ignored
        start_i = 1'b1; func_i = 6'b011100; opa_i = 5; opb_i = 6;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check(!busy_o && hi_o == 32'hA5A5_0001 && lo_o == 32'h1234, "R2", "bad code",
              {31'd0, busy_o, lo_o}, {32'd0, 32'h1234});

        // R3: unsigned multiply
        issue(6'b011001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
        issue(6'b011001, 32'd12345, 32'd6789, "R3");
        // R4: signed multiply
        issue(6'b011000, -32'sd3, 32'd7, "R4");
        issue(6'b011000, 32'h8000_0000, 32'h8000_0000, "R4");
        issue(6'b011000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
        // R5: unsigned divide
        issue(6'b011011, 32'd100, 32'd7, "R5");
        issue(6'b011011, 32'hFFFF_FFFF, 32'h10, "R5");
        // R6: signed divide
        issue(6'b011010, -32'sd7, 32'd2, "R6");
        issue(6'b011010, 32'd7, -32'sd2, "R6");
        issue(6'b011010, 32'h8000_0000, 32'hFFFF_FFFF, "R6");
        // R12: divide by zero completes, unit still usable after
        issue(6'b011011, 32'd99, 32'd0, "R12");
        issue(6'b011010, -32'sd99, 32'd0, "R12");
        issue(6'b011011, 32'd1000, 32'd10, "R12");
        wait_idle();

        // R8, R9, R11: interference during a running operation
        begin
            logic [31:0] hold_hi, hold_lo;
            hold_hi = hi_o; hold_lo = lo_o;
            issue(6'b011001, 32'd40000, 32'd70000, "R9");
            repeat (5) @(negedge clk);
            start_i = 1'b1; func_i = 6'b011011; opa_i = 77; opb_i = 3;
            mthi_i = 1'b1; mtlo_i = 1'b1; mt_data_i = 32'hDEAD_BEEF;
            @(negedge clk);
            start_i = 1'b0; mthi_i = 1'b0; mtlo_i = 1'b0;
            repeat (3) @(negedge clk);
            check(busy_o && hi_o == hold_hi && lo_o == hold_lo, "R8", "hold while busy",
                  {hi_o, lo_o}, {hold_hi, hold_lo});
            wait_idle();
            check(!busy_o, "R9", "no second operation", {63'd0, busy_o}, 64'd0);
        end

        // R11: start and move-to in the same idle cycle, start wins
        while (busy_o) @(negedge clk);
        mthi_i = 1'b1; mt_data_i = 32'h1111_2222;
        issue(6'b011000, 32'd6, -32'sd5, "R11");
        mthi_i = 1'b0;
        wait_idle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R7 watchdog actual=stuck expected=complete");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule